// File: doc/BRIEF.md
# Fractional-N Clock Divider with Accumulator Ratio Control

This block is the programmable feedback divider of a frequency synthesizer. It divides its input clock by a whole number N or by N+1. The ratio for each output period is picked by a K-bit phase accumulator. Each time an output period ends, the accumulator adds the fractional word to itself. The carry out of that addition makes the next period one input clock longer. Over many periods the mean division ratio is N + frac/2^K. The accumulator acts as a first-order sigma-delta modulator, so a constant fractional word gives a periodic carry pattern.

The accumulator's current value tracks the phase error that builds up between the divided clock and an ideal fractional clock. It is brought out as a residue word, so logic downstream can cancel the predictable ripple. The integer and fractional inputs are sampled only at the clock edge that ends a period. A change made part way through a period therefore never shortens or stretches that period.

The control is a two-state machine. ST_LOAD is entered at reset. Its only transition, named *start*, leads to ST_COUNT; it loads the down-counter with N-1 and clears the accumulator. ST_COUNT has two self-transitions. *Count* decrements the counter while it is non-zero. *Reload* fires when the counter is zero: it raises the output pulse, steps the accumulator and loads the counter with N-1+carry.

Top module: `fracn_divider`

## Requirements
- R1: While reset is asserted, div_pulse, ratio_sel and residue are all 0. The first clock edge after reset is released loads the counter from int_div, leaves ratio_sel at 0 and clears the residue. The first div_pulse is then seen N clock edges after the release.
- R2: div_pulse is high for exactly one clock cycle at the end of each output period. A period during which ratio_sel reads 0 lasts N input clocks, and one during which ratio_sel reads 1 lasts N+1 input clocks.
- R3: At the clock edge that ends a pulse-high cycle, the concatenation {ratio_sel, residue} takes the value residue + frac_word. The addition is done as K+1-bit unsigned, so residue wraps modulo 2^K and ratio_sel receives the carry.
- R4: The value ratio_sel takes at a reload sets the length of the output period that starts at that edge: N+1 clocks when ratio_sel is 1, N clocks when it is 0.
- R5: int_div and frac_word are sampled only at the clock edge that ends a pulse-high cycle. Values they hold at any other edge have no effect on period lengths, residue or ratio_sel.
- R6: residue and ratio_sel hold their values at every clock edge that is not a reload.
- R7: With a constant fractional word F, exactly F of any 2^K consecutive output periods use the ratio N+1. With F = 0, no period uses N+1.
- R8: int_div must be non-zero. N = 1 is supported: its periods are 1 clock with ratio_sel at 0, so pulses come back to back, and 2 clocks with ratio_sel at 1. The largest int_div, 2^NW-1, with a carry gives a 2^NW-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_div | input | NW | Integer division ratio N, non-zero |
| frac_word | input | KW | Fractional word added at each period end |
| div_pulse | output | 1 | One-clock pulse at the end of each output period |
| ratio_sel | output | 1 | 1 when the current output period uses N+1 |
| residue | output | KW | Accumulator value, the phase-error correction word |

## Verification
The assertions take int_div to be non-zero whenever reset is released. A zero N has no meaning, and the reload arithmetic would wrap to the longest period. frac_word may hold any value. The stimulus draws every integer ratio from 1 upward, including the noise values written in the middle of a period, so the non-zero rule is never broken. The random noise on both inputs between reloads exercises the sampling rule, and the directed phases hold the fractional word constant for 2^K periods to check the exact carry density.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    // Control states of the divider
    typedef enum logic [0:0] {
        ST_LOAD  = 1'b0,   // first load after reset
        ST_COUNT = 1'b1    // counting down, reloading at zero
    } fdiv_state_t;

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum #(
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [KW-1:0] frac,
    output logic [KW-1:0] residue,
    output logic          carry_q,
    output logic          carry_next
);

    localparam int SW = KW + 1;

    logic [SW-1:0] sum_w;

    assign sum_w      = {1'b0, residue} + {1'b0, frac};
    assign carry_next = sum_w[SW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            residue <= '0;
            carry_q <= 1'b0;
        end else if (clear) begin
            residue <= '0;
            carry_q <= 1'b0;
        end else if (step) begin
            {carry_q, residue} <= sum_w;
        end
    end

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear) |=> ({carry_q, residue} == ({1'b0, $past(residue)} + {1'b0, $past(frac)}))); // R3

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(residue) && $stable(carry_q))); // R6

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (residue == '0 && !carry_q)); // R1

endmodule

// File: rtl/fracn_count.sv
module fracn_count #(
    parameter int NW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] load_val,
    output logic [NW-1:0] cnt,
    output logic          at_zero
);

    localparam logic [NW-1:0] ONE_W = {{(NW-1){1'b0}}, 1'b1};

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (!at_zero) begin
            cnt <= cnt - ONE_W;
        end
    end

    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - ONE_W)); // R2

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
    import fracn_pkg::*;
#(
    parameter int NW = 8,
    parameter int KW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] int_div,
    input  logic [KW-1:0] frac_word,
    output logic          div_pulse,
    output logic          ratio_sel,
    output logic [KW-1:0] residue
);

    localparam logic [NW-1:0] ONE_W = {{(NW-1){1'b0}}, 1'b1};

    fdiv_state_t   state_q, state_d;
    logic          load_first;
    logic          reload;
    logic          cnt_load;
    logic          carry_next;
    logic          carry_use;
    logic          at_zero;
    logic [NW-1:0] cnt;
    logic [NW-1:0] load_val;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: start leaves ST_LOAD, count and reload stay in ST_COUNT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:  state_d = ST_COUNT;
            ST_COUNT: state_d = ST_COUNT;
        endcase
    end

    // Control outputs of the state machine
    always_comb begin
        load_first = 1'b0;
        reload     = 1'b0;
        unique case (state_q)
            ST_LOAD:  load_first = 1'b1;
            ST_COUNT: reload     = at_zero;
        endcase
    end

    assign carry_use = reload & carry_next;
    assign load_val  = int_div - ONE_W + {{(NW-1){1'b0}}, carry_use};
    assign cnt_load  = load_first | reload;
    assign div_pulse = reload;

    fracn_count #(.NW(NW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .cnt      (cnt),
        .at_zero  (at_zero)
    );

    fracn_accum #(.KW(KW)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load_first),
        .step       (reload),
        .frac       (frac_word),
        .residue    (residue),
        .carry_q    (ratio_sel),
        .carry_next (carry_next)
    );

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        int_div != '0); // R8

    AST_FIRST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (cnt == $past(int_div) - ONE_W && !ratio_sel)); // R1

    AST_RELOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> (cnt == $past(int_div) - ONE_W + {{(NW-1){1'b0}}, ratio_sel})); // R4

    AST_STAY_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |=> (state_q == ST_COUNT)); // R2

endmodule

// File: tb/tb_fracn_divider.sv
module tb_fracn_divider;

    localparam int NW = 4;
    localparam int KW = 8;
    localparam int NPER = 1 << KW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] int_div = 4'd3;
    logic [KW-1:0] frac_word = '0;
    logic          div_pulse;
    logic          ratio_sel;
    logic [KW-1:0] residue;

    always #5 clk = ~clk;

    fracn_divider #(.NW(NW), .KW(KW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_div   (int_div),
        .frac_word (frac_word),
        .div_pulse (div_pulse),
        .ratio_sel (ratio_sel),
        .residue   (residue)
    );

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;

    // bench model state
    logic [KW-1:0] m_acc;
    logic          m_sel;
    int            exp_len;
    int            cyc;
    bit            pend;
    bit            first_per;
    bit            pulse_seen;
    int            pend_cnt;
    int            sel_ones;
    int            nxt_n;      // 0 = random in 1..7
    logic [KW-1:0] nxt_frac;
    bit            noise;

    function automatic logic [KW:0] acc_add(input logic [KW-1:0] a, input logic [KW-1:0] f);
        return {1'b0, a} + {1'b0, f};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            summary();
        end
    end

    // one negedge of observation and driving
    task automatic tick();
        logic [KW:0] s;
        @(negedge clk);
        cyc++;
        pulse_seen = 1'b0;
        if (pend) begin
            check(residue == m_acc, "R3 residue after reload", residue, m_acc);
            check(ratio_sel == m_sel, "R3 ratio_sel carry", ratio_sel, m_sel);
            if (ratio_sel) sel_ones++;
            pend_cnt++;
            pend = 1'b0;
        end else begin
            check(residue == m_acc && ratio_sel == m_sel,
                  noise ? "R5 R6 hold under input noise" : "R6 hold between reloads",
                  {ratio_sel, residue}, {m_sel, m_acc});
        end
        if (div_pulse) begin
            check(cyc == exp_len, first_per ? "R1 first period" :
                  (noise ? "R5 period under noise" : "R2 R4 period length"), cyc, exp_len);
            first_per = 1'b0;
            int_div   = (nxt_n == 0) ? NW'(1 + ($urandom % 7)) : NW'(nxt_n);
            frac_word = nxt_frac;
            s = acc_add(m_acc, frac_word);
            m_acc   = s[KW-1:0];
            m_sel   = s[KW];
            exp_len = int'(int_div) + int'(m_sel);
            cyc     = 0;
            pend    = 1'b1;
            pulse_seen = 1'b1;
        end else begin
            if (cyc > exp_len) check(1'b0, "R2 missing pulse", cyc, exp_len);
            if (noise && ($urandom % 2 == 0)) begin
                int_div   = NW'(1 + ($urandom % 15));
                frac_word = KW'($urandom);
            end
        end
    endtask

    // hold F constant for 2^K periods and count N+1 periods
    task automatic density(input logic [KW-1:0] f, input int n_mode, input bit nz);
        nxt_frac = f;
        nxt_n    = n_mode;
        noise    = nz;
        do tick(); while (!pulse_seen);
        sel_ones = 0;
        pend_cnt = 0;
        while (pend_cnt < NPER) tick();
        check(sel_ones == int'(f), "R7 carry density", sel_ones, f);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_acc = '0; m_sel = 1'b0; pend = 1'b0; cyc = 0; exp_len = 0;
        first_per = 1'b1; pend_cnt = 0; sel_ones = 0;
        nxt_n = 3; nxt_frac = '0; noise = 1'b0;

        // R1: reset values
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R1 reset div_pulse", div_pulse, 0);
        check(ratio_sel == 1'b0, "R1 reset ratio_sel", ratio_sel, 0);
        check(residue == '0, "R1 reset residue", residue, 0);

        @(negedge clk);
        int_div = 4'd3;
        frac_word = 8'd77;
        rst_n = 1'b1;
        exp_len = 3;
        cyc = 0;

        // a few periods with a fixed ratio, then directed corner cases
        nxt_frac = 8'd77;
        repeat (20) tick();

        density(8'd0,   3, 1'b0);   // R7: F = 0 never uses N+1
        density(8'd1,   0, 1'b0);
        density(8'd128, 0, 1'b0);
        density(8'd255, 1, 1'b0);   // R8: N = 1, back-to-back pulses
        density(8'd0,   1, 1'b0);   // R8: N = 1 with no carry
        density(8'd200, 15, 1'b0);  // R8: largest N with carries
        density(8'd93,  0, 1'b1);   // R5: noise between reloads
        density(KW'($urandom), 0, 1'b1);
        density(KW'($urandom), 0, 1'b0);

        // random fractional word at every period
        noise = 1'b1;
        nxt_n = 0;
        for (int i = 0; i < 400; i++) begin
            nxt_frac = KW'($urandom);
            tick();
        end

        summary();
    end

endmodule